// File: doc/BRIEF.md
# Buffered Saturating Error Counter Bank

This block keeps five 16-bit counters of line error events for performance monitoring. The five events are code violations, framing bit errors, CRC6 errors, errored blocks and PRBS bit errors. Each event arrives as a one-cycle pulse on its own line. A counter never wraps. When it reaches 0xFFFF it stays there until it is cleared.

Software does not read the live counters. It reads a holding buffer kept beside each counter. A snapshot copies every counter into its buffer in the same cycle and restarts the counters. Two modes pick what triggers a snapshot. In periodic mode, an external one-second tick triggers it. In demand mode, a software write to a latch-request strobe triggers it. The write raises a busy flag that software can poll, and the flag clears as the snapshot lands.

Reads use a valid/ready request channel that carries a counter select. The response channel returns the buffer value with valid/ready. A request is taken only when no response is pending or the pending one is consumed in the same cycle. While the consumer holds `rsp_ready_i` low, the response stays valid and its data does not change.

Top module: `err_cnt_bank`

## Requirements
- R1: Each of the five counters adds one for each cycle its own event bit is high. Events on several bits in the same cycle are all counted in that cycle. Bit and select order: 0 code violation, 1 framing bit, 2 CRC6, 3 errored block, 4 PRBS.
- R2: With `mode_demand_i` low, a `sec_tick_i` pulse copies every counter into its buffer and restarts every counter. In this mode `latch_wr_i` is ignored and `latch_busy_o` stays low.
- R3: With `mode_demand_i` high, `latch_busy_o` is high in the cycle after a `latch_wr_i` pulse. On the clock edge that ends that cycle, every buffer loads and the counters restart. In this mode `sec_tick_i` has no effect.
- R4: A counter at 0xFFFF stays at 0xFFFF on further events until the next snapshot clears it.
- R5: An event in the cycle of a snapshot is not lost. The counter holds 1 after that snapshot.
- R6: A read is accepted when `rd_valid_i` and `rd_ready_o` are both high. `rsp_valid_o` rises on the next cycle with the buffer value as it stood at acceptance. A select of 5 to 7 returns 0.
- R7: `rd_ready_o` equals `!rsp_valid_o || rsp_ready_i`. While `rsp_valid_o` is high and `rsp_ready_i` is low, `rsp_valid_o` and `rsp_data_o` hold.
- R8: After reset, all counters and buffers are zero and `latch_busy_o` and `rsp_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 5 | One-cycle event pulses, one bit per counter |
| sec_tick_i | input | 1 | One-second tick |
| mode_demand_i | input | 1 | 1: demand snapshots, 0: periodic snapshots |
| latch_wr_i | input | 1 | Software latch-request write strobe |
| latch_busy_o | output | 1 | Latch request pending |
| rd_valid_i | input | 1 | Read request valid |
| rd_sel_i | input | 3 | Counter select |
| rd_ready_o | output | 1 | Read request ready |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_data_o | output | 16 | Buffer value |
| rsp_ready_i | input | 1 | Read response ready |

## Verification
The live counters cannot be seen directly. A wrong count, a lost event in the snapshot cycle, or a wrap past 0xFFFF first shows up one snapshot later, in the buffer value returned by the next read. The bench therefore snapshots and reads back after every stimulus pattern. A wrong busy flag or a bad response handshake is visible on the very next cycle. A cycle-level model checks these every clock.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int NUM_CNT = 5;
  localparam int CNT_W   = 16;
  localparam int SEL_W   = $clog2(NUM_CNT + 1);
  typedef enum logic [2:0] {
    EV_CODE  = 3'd0,
    EV_FRAME = 3'd1,
    EV_CRC   = 3'd2,
    EV_BLOCK = 3'd3,
    EV_PRBS  = 3'd4
  } evc_idx_e;
endpackage

// File: rtl/evc_cell.sv
module evc_cell #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic         clr,
  output logic [W-1:0] hold
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      hold <= '0;
    end else if (clr) begin
      hold <= cnt;
      cnt  <= {{(W-1){1'b0}}, evt};
    end else if (evt && cnt != MAXV) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXV && !clr) |=> cnt == MAXV);
  // R5
  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == {{(W-1){1'b0}}, $past(evt)});
  // R1
  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && evt && cnt != MAXV) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/evc_snap_ctrl.sv
module evc_snap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic mode_demand,
  input  logic latch_wr,
  output logic busy,
  output logic snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy <= 1'b0;
    else        busy <= mode_demand & latch_wr;
  end

  always_comb snap = mode_demand ? busy : tick;

  // R3
  a_r3_busy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_demand && latch_wr) |=> busy);
  // R3
  a_r3_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_demand && !busy) |-> !snap);
  // R2
  a_r2_no_busy_periodic: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_demand |=> !busy);
endmodule

// File: rtl/evc_rd_port.sv
module evc_rd_port #(
  parameter int N     = 5,
  parameter int W     = 16,
  parameter int SEL_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0][W-1:0] bufs,
  input  logic                rd_valid,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic                rd_ready,
  output logic                rsp_valid,
  output logic [W-1:0]        rsp_data,
  input  logic                rsp_ready
);
  logic         take;
  logic [W-1:0] pick;

  always_comb begin
    rd_ready = !rsp_valid || rsp_ready;
    take     = rd_valid && rd_ready;
    pick     = '0;
    for (int i = 0; i < N; i++)
      if (rd_sel == SEL_W'(i)) pick = bufs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      rsp_data  <= pick;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_data));
  // R6
  a_r6_resp_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rsp_valid);
endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank #(
  parameter int NUM_CNT = evc_pkg::NUM_CNT,
  parameter int CNT_W   = evc_pkg::CNT_W,
  parameter int SEL_W   = evc_pkg::SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CNT-1:0] evt_i,
  input  logic               sec_tick_i,
  input  logic               mode_demand_i,
  input  logic               latch_wr_i,
  output logic               latch_busy_o,
  input  logic               rd_valid_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic               rd_ready_o,
  output logic               rsp_valid_o,
  output logic [CNT_W-1:0]   rsp_data_o,
  input  logic               rsp_ready_i
);
  logic                          snap;
  logic [NUM_CNT-1:0][CNT_W-1:0] bufs;

  evc_snap_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick_i), .mode_demand(mode_demand_i),
    .latch_wr(latch_wr_i), .busy(latch_busy_o), .snap(snap)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cell
    evc_cell #(.W(CNT_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .evt(evt_i[g]), .clr(snap), .hold(bufs[g])
    );
  end

  evc_rd_port #(.N(NUM_CNT), .W(CNT_W), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .bufs(bufs), .rd_valid(rd_valid_i),
    .rd_sel(rd_sel_i), .rd_ready(rd_ready_o), .rsp_valid(rsp_valid_o),
    .rsp_data(rsp_data_o), .rsp_ready(rsp_ready_i)
  );

  // R8
  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !latch_busy_o && !rsp_valid_o);
endmodule

// File: tb/tb_err_cnt_bank.sv
`timescale 1ns/1ps
module tb_err_cnt_bank;
  logic clk = 0, rst_n = 0;
  logic [4:0] evt = 0;
  logic tick = 0, mode = 0, lwr = 0, rdv = 0, rrdy = 1;
  logic [2:0] sel = 0;
  logic busy, rdy, rv;
  logic [15:0] rd;
  int total = 0, bad = 0, cyc = 0;

  int m_cnt[5], m_buf[5];
  bit m_busy, m_rv;
  int m_rd;

  always #4 clk = ~clk;

  err_cnt_bank dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .sec_tick_i(tick),
    .mode_demand_i(mode), .latch_wr_i(lwr), .latch_busy_o(busy),
    .rd_valid_i(rdv), .rd_sel_i(sel), .rd_ready_o(rdy),
    .rsp_valid_o(rv), .rsp_data_o(rd), .rsp_ready_i(rrdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated at each edge
  always @(posedge clk) begin
    bit snap;
    cyc++;
    if (!rst_n) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_buf[i] = 0; end
      m_busy = 0; m_rv = 0; m_rd = 0;
    end else begin
      snap = mode ? m_busy : tick;
      if (rdv && (!m_rv || rrdy)) begin
        m_rv = 1; m_rd = (sel < 5) ? m_buf[sel] : 0;
      end else if (rrdy) m_rv = 0;
      for (int i = 0; i < 5; i++) begin
        if (snap) begin m_buf[i] = m_cnt[i]; m_cnt[i] = evt[i]; end
        else if (evt[i] && m_cnt[i] < 65535) m_cnt[i]++;
      end
      m_busy = mode && lwr;
    end
    #2;
    if (rst_n) begin
      chk(busy === m_busy, "R3 busy", busy, m_busy);
      chk(rv === m_rv, "R6 rsp_valid", rv, m_rv);
      if (m_rv) chk(rd === m_rd[15:0], "R6 rsp_data", rd, m_rd);
      chk(rdy === (!m_rv || rrdy), "R7 rd_ready", rdy, !m_rv || rrdy);
    end
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic rdb(input int s, input int exp, input string tag);
    @(negedge clk); rdv = 1; sel = 3'(s); rrdy = 1;
    @(negedge clk); rdv = 0;
    chk(rv === 1'b1 && rd === exp[15:0], tag, rd, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic latch();
    @(negedge clk); lwr = 1; @(negedge clk); lwr = 0; @(negedge clk);
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    chk(busy === 0 && rv === 0, "R8 reset flags", {busy, rv}, 0);
    for (int i = 0; i < 5; i++) rdb(i, 0, "R8 buffer zero");

    // R1: all five at once, plus extra on bits 2 and 4
    @(negedge clk); evt = 5'b11111;
    @(negedge clk); evt = 5'b10100;
    @(negedge clk); evt = 5'b10000;
    @(negedge clk); evt = 0;
    pulse_tick();
    rdb(0, 1, "R1 code"); rdb(1, 1, "R1 frame"); rdb(2, 2, "R1 crc");
    rdb(3, 1, "R1 block"); rdb(4, 3, "R1 prbs");

    // R5: event on snapshot cycle
    @(negedge clk); tick = 1; evt = 5'b00010;
    @(negedge clk); tick = 0; evt = 0;
    pulse_tick();
    rdb(1, 1, "R5 restart at one");

    // R2: latch write ignored in periodic mode
    @(negedge clk); evt = 5'b00001; lwr = 1;
    @(negedge clk); evt = 0; lwr = 0;
    #3 chk(busy === 0, "R2 write ignored", busy, 0);
    rdb(0, 0, "R2 buffer unchanged");

    // R3: demand mode, tick ignored then latch
    @(negedge clk); mode = 1; evt = 5'b01000;
    @(negedge clk); evt = 0; tick = 1;
    @(negedge clk); tick = 0;
    rdb(3, 0, "R3 tick ignored");
    @(negedge clk); lwr = 1;
    @(negedge clk); lwr = 0;
    #3 chk(busy === 1, "R3 busy raised", busy, 1);
    @(negedge clk);
    #3 chk(busy === 0, "R3 busy cleared", busy, 0);
    rdb(3, 1, "R3 demand latch");

    // R6: out-of-range select
    rdb(6, 0, "R6 bad select");

    // R7: back-pressure
    @(negedge clk); rdv = 1; sel = 3'd3; rrdy = 0;
    @(negedge clk); rdv = 1; sel = 3'd0;
    #3 chk(rdy === 0 && rv === 1, "R7 stall", {rdy, rv}, 2'b01);
    @(negedge clk); rdv = 0;
    chk(rd === 16'd1, "R7 data held", rd, 1);
    rrdy = 1; step(2);

    // R4: saturation
    latch();
    @(negedge clk); evt = 5'b00001;
    step(65600);
    evt = 0;
    latch();
    rdb(0, 65535, "R4 saturate");
    latch();
    rdb(0, 0, "R4 cleared after snapshot");

    step(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule